// File: doc/BRIEF.md
# Burst-Four Shared-Bus DDR SRAM Engine

This block is a cycle-accurate, synthesizable model of the device side of a synchronous SRAM. The SRAM moves data at double rate over one shared data bus, and every access is a fixed burst of four beats. The design runs on a single clock. Each clock cycle carries two beats: one on the rise-half port and one on the fall-half port. A command is sampled on the rising edge. The command is a four-beat group address plus a read strobe or a write strobe.

Write data arrives after the command. The first two beats come in the next cycle and the last two beats in the cycle after that. Each beat has its own byte-lane enables. The captured burst waits in a one-entry write buffer and is committed to the storage array one cycle later. Read data comes out two cycles after the read command, two beats per cycle. A read that overlaps a write still waiting in the buffer sees the new bytes. Because a burst holds the bus for two cycles, a command is accepted at most every other cycle. Misuse of the interface sets a sticky error flag.

Top module: `b4_cio_sram`

## Requirements
- R1: After reset, `rvalid_o` and `proto_err_o` are 0, both read-data ports are 0, and every storage word reads back as 0.
- R2: A read command accepted in cycle c drives beat 0 on `rdata_rise_o` and beat 1 on `rdata_fall_o` in cycle c+2, then beats 2 and 3 in cycle c+3. `rvalid_o` is 1 in exactly the cycles in which read beats are driven. Both read-data ports are 0 whenever `rvalid_o` is 0.
- R3: The two low address bits are ignored. Beat i of a burst reaches word {addr[ADDR_W-1:2], i}, so addresses that differ only in those bits reach the same four words.
- R4: For a write command in cycle c, beats 0 and 1 are taken from `wdata_rise_i` and `wdata_fall_i` in cycle c+1, and beats 2 and 3 from the same ports in cycle c+2.
- R5: Each data beat has its own mask, taken from the port that carries that beat. Bit b of `wbe_rise_i` or `wbe_fall_i`, when 1, writes lane b, which is bits [b*LANE_W +: LANE_W] of the word. A lane whose bit is 0 keeps its old value.
- R6: A read issued in the earliest cycle allowed after a write, which is two cycles after the write command, returns the newly written bytes merged with the unchanged ones.
- R7: A read or write command in the cycle right after an accepted command is ignored: no data moves and no word changes. It sets `proto_err_o`.
- R8: When read and write are asserted together, only the read is performed, the write is dropped and `proto_err_o` is set.
- R9: `proto_err_o` stays 1 until reset once set.
- R10: Commands spaced exactly two cycles apart are all accepted without error, including a write followed by a write and a write followed by reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Command address; low two bits ignored |
| rd_en_i | input | 1 | Read command strobe |
| wr_en_i | input | 1 | Write command strobe |
| wdata_rise_i | input | LANES*LANE_W | Write beat 0 or 2 |
| wdata_fall_i | input | LANES*LANE_W | Write beat 1 or 3 |
| wbe_rise_i | input | LANES | Lane enables for beat 0 or 2 |
| wbe_fall_i | input | LANES | Lane enables for beat 1 or 3 |
| rdata_rise_o | output | LANES*LANE_W | Read beat 0 or 2 |
| rdata_fall_o | output | LANES*LANE_W | Read beat 1 or 3 |
| rvalid_o | output | 1 | High while read beats are driven |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench uses the default parameters: a 5-bit address, which gives eight four-word groups, and two 8-bit lanes per word. With eight groups, a short vector table can revisit the same group through aligned and unaligned addresses, so partial writes are merged over earlier contents. With two lanes, every mix of enabled and masked lanes per beat can be reached. The small size also lets the bench hold a full reference copy of the array and compare every read beat against it, including the forwarded read right after a write and the dropped writes from rejected commands.

// File: rtl/b4_sram_pkg.sv
`timescale 1ns/1ps
package b4_sram_pkg;
    localparam int BURST_LEN  = 4;
    localparam int BEAT_SEL_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // read wins when both strobes are present
    function automatic op_e decode_op(input logic rd, input logic wr);
        if (rd) return OP_READ;
        if (wr) return OP_WRITE;
        return OP_NONE;
    endfunction
endpackage

// File: rtl/b4_cmd_ctrl.sv
`timescale 1ns/1ps
module b4_cmd_ctrl
    import b4_sram_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             busy_o,
    output logic             rd_go_o,
    output logic             wr_go_o,
    output logic [ROW_W-1:0] go_row_o,
    output logic             err_o
);
    op_e  op;
    logic req, accept, bad;

    always_comb begin
        op     = decode_op(rd_en_i, wr_en_i);
        req    = (op != OP_NONE);
        accept = req && !busy_o;
        bad    = (req && busy_o) || (rd_en_i && wr_en_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            rd_go_o  <= 1'b0;
            wr_go_o  <= 1'b0;
            go_row_o <= '0;
            err_o    <= 1'b0;
        end else begin
            busy_o  <= accept;
            rd_go_o <= accept && (op == OP_READ);
            wr_go_o <= accept && (op == OP_WRITE);
            if (accept) go_row_o <= row_i;
            if (bad)    err_o    <= 1'b1;
        end
    end
endmodule

// File: rtl/b4_write_buf.sv
`timescale 1ns/1ps
module b4_write_buf
    import b4_sram_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_go_i,
    input  logic [ROW_W-1:0]                    row_i,
    input  logic [DW-1:0]                       wd_rise_i,
    input  logic [DW-1:0]                       wd_fall_i,
    input  logic [LANES-1:0]                    be_rise_i,
    input  logic [LANES-1:0]                    be_fall_i,
    output logic                                commit_o,
    output logic [ROW_W-1:0]                    commit_row_o,
    output logic [BURST_LEN-1:0][DW-1:0]        commit_data_o,
    output logic [BURST_LEN-1:0][LANES-1:0]     commit_be_o
);
    logic                 stage_vld;
    logic [ROW_W-1:0]     stage_row;
    logic [1:0][DW-1:0]   stage_data;
    logic [1:0][LANES-1:0] stage_be;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_vld     <= 1'b0;
            stage_row     <= '0;
            stage_data    <= '0;
            stage_be      <= '0;
            commit_o      <= 1'b0;
            commit_row_o  <= '0;
            commit_data_o <= '0;
            commit_be_o   <= '0;
        end else begin
            stage_vld <= wr_go_i;
            if (wr_go_i) begin
                stage_row     <= row_i;
                stage_data[0] <= wd_rise_i;
                stage_data[1] <= wd_fall_i;
                stage_be[0]   <= be_rise_i;
                stage_be[1]   <= be_fall_i;
            end
            commit_o <= stage_vld;
            if (stage_vld) begin
                commit_row_o     <= stage_row;
                commit_data_o[0] <= stage_data[0];
                commit_data_o[1] <= stage_data[1];
                commit_data_o[2] <= wd_rise_i;
                commit_data_o[3] <= wd_fall_i;
                commit_be_o[0]   <= stage_be[0];
                commit_be_o[1]   <= stage_be[1];
                commit_be_o[2]   <= be_rise_i;
                commit_be_o[3]   <= be_fall_i;
            end
        end
    end
endmodule

// File: rtl/b4_store.sv
`timescale 1ns/1ps
module b4_store
    import b4_sram_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = BURST_LEN << ROW_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we_i,
    input  logic [ROW_W-1:0]                wrow_i,
    input  logic [BURST_LEN-1:0][DW-1:0]    wdata_i,
    input  logic [BURST_LEN-1:0][LANES-1:0] wbe_i,
    input  logic [ROW_W-1:0]                rrow_i,
    input  logic                            rhi_i,
    output logic [DW-1:0]                   rword_even_o,
    output logic [DW-1:0]                   rword_odd_o
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we_i) begin
            for (int bt = 0; bt < BURST_LEN; bt++) begin
                for (int ln = 0; ln < LANES; ln++) begin
                    if (wbe_i[bt][ln])
                        mem[{wrow_i, BEAT_SEL_W'(bt)}][ln*LANE_W +: LANE_W]
                            <= wdata_i[bt][ln*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rword_even_o = mem[{rrow_i, rhi_i, 1'b0}];
    assign rword_odd_o  = mem[{rrow_i, rhi_i, 1'b1}];
endmodule

// File: rtl/b4_read_port.sv
`timescale 1ns/1ps
module b4_read_port
    import b4_sram_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_go_i,
    input  logic [ROW_W-1:0]                go_row_i,
    input  logic [DW-1:0]                   mem_even_i,
    input  logic [DW-1:0]                   mem_odd_i,
    input  logic                            buf_vld_i,
    input  logic [ROW_W-1:0]                buf_row_i,
    input  logic [BURST_LEN-1:0][DW-1:0]    buf_data_i,
    input  logic [BURST_LEN-1:0][LANES-1:0] buf_be_i,
    output logic [ROW_W-1:0]                sel_row_o,
    output logic                            sel_hi_o,
    output logic [DW-1:0]                   rdata_rise_o,
    output logic [DW-1:0]                   rdata_fall_o,
    output logic                            rvalid_o
);
    logic             tail_vld;
    logic [ROW_W-1:0] tail_row;
    logic             hit;
    logic [BEAT_SEL_W-1:0] even_beat, odd_beat;
    logic [DW-1:0]    even_m, odd_m;

    always_comb begin
        sel_hi_o  = !rd_go_i;
        sel_row_o = rd_go_i ? go_row_i : tail_row;
        hit       = buf_vld_i && (buf_row_i == sel_row_o);
        even_beat = {sel_hi_o, 1'b0};
        odd_beat  = {sel_hi_o, 1'b1};
    end

    // forward still-buffered bytes lane by lane
    for (genvar ln = 0; ln < LANES; ln++) begin : g_fwd
        assign even_m[ln*LANE_W +: LANE_W] = (hit && buf_be_i[even_beat][ln])
            ? buf_data_i[even_beat][ln*LANE_W +: LANE_W]
            : mem_even_i[ln*LANE_W +: LANE_W];
        assign odd_m[ln*LANE_W +: LANE_W] = (hit && buf_be_i[odd_beat][ln])
            ? buf_data_i[odd_beat][ln*LANE_W +: LANE_W]
            : mem_odd_i[ln*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_vld     <= 1'b0;
            tail_row     <= '0;
            rdata_rise_o <= '0;
            rdata_fall_o <= '0;
            rvalid_o     <= 1'b0;
        end else if (rd_go_i) begin
            rdata_rise_o <= even_m;
            rdata_fall_o <= odd_m;
            rvalid_o     <= 1'b1;
            tail_vld     <= 1'b1;
            tail_row     <= go_row_i;
        end else if (tail_vld) begin
            rdata_rise_o <= even_m;
            rdata_fall_o <= odd_m;
            rvalid_o     <= 1'b1;
            tail_vld     <= 1'b0;
        end else begin
            rdata_rise_o <= '0;
            rdata_fall_o <= '0;
            rvalid_o     <= 1'b0;
        end
    end
endmodule

// File: rtl/b4_cio_sram.sv
`timescale 1ns/1ps
module b4_cio_sram
    import b4_sram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    rd_en_i,
    input  logic                    wr_en_i,
    input  logic [LANES*LANE_W-1:0] wdata_rise_i,
    input  logic [LANES*LANE_W-1:0] wdata_fall_i,
    input  logic [LANES-1:0]        wbe_rise_i,
    input  logic [LANES-1:0]        wbe_fall_i,
    output logic [LANES*LANE_W-1:0] rdata_rise_o,
    output logic [LANES*LANE_W-1:0] rdata_fall_o,
    output logic                    rvalid_o,
    output logic                    proto_err_o
);
    localparam int ROW_W = ADDR_W - BEAT_SEL_W;
    localparam int DW    = LANES * LANE_W;

    logic [BEAT_SEL_W-1:0] addr_low_unused;
    logic                  busy_w, rd_go_w, wr_go_w;
    logic [ROW_W-1:0]      go_row_w, sel_row_w, cm_row_w;
    logic                  sel_hi_w, cm_vld_w;
    logic [BURST_LEN-1:0][DW-1:0]    cm_data_w;
    logic [BURST_LEN-1:0][LANES-1:0] cm_be_w;
    logic [DW-1:0]         mem_even_w, mem_odd_w;

    assign addr_low_unused = addr_i[BEAT_SEL_W-1:0];

    b4_cmd_ctrl #(.ROW_W(ROW_W)) u_cmd (
        .clk(clk), .rst(rst),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .row_i(addr_i[ADDR_W-1:BEAT_SEL_W]),
        .busy_o(busy_w), .rd_go_o(rd_go_w), .wr_go_o(wr_go_w),
        .go_row_o(go_row_w), .err_o(proto_err_o)
    );

    b4_write_buf #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst(rst),
        .wr_go_i(wr_go_w), .row_i(go_row_w),
        .wd_rise_i(wdata_rise_i), .wd_fall_i(wdata_fall_i),
        .be_rise_i(wbe_rise_i), .be_fall_i(wbe_fall_i),
        .commit_o(cm_vld_w), .commit_row_o(cm_row_w),
        .commit_data_o(cm_data_w), .commit_be_o(cm_be_w)
    );

    b4_store #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .rst(rst),
        .we_i(cm_vld_w), .wrow_i(cm_row_w),
        .wdata_i(cm_data_w), .wbe_i(cm_be_w),
        .rrow_i(sel_row_w), .rhi_i(sel_hi_w),
        .rword_even_o(mem_even_w), .rword_odd_o(mem_odd_w)
    );

    b4_read_port #(.ROW_W(ROW_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst(rst),
        .rd_go_i(rd_go_w), .go_row_i(go_row_w),
        .mem_even_i(mem_even_w), .mem_odd_i(mem_odd_w),
        .buf_vld_i(cm_vld_w), .buf_row_i(cm_row_w),
        .buf_data_i(cm_data_w), .buf_be_i(cm_be_w),
        .sel_row_o(sel_row_w), .sel_hi_o(sel_hi_w),
        .rdata_rise_o(rdata_rise_o), .rdata_fall_o(rdata_fall_o),
        .rvalid_o(rvalid_o)
    );
endmodule

// File: rtl/b4_sram_chk.sv
`timescale 1ns/1ps
module b4_sram_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          wr_en,
    input logic          busy,
    input logic          rd_go,
    input logic          wr_go,
    input logic          rvalid,
    input logic [DW-1:0] rdata_rise,
    input logic [DW-1:0] rdata_fall,
    input logic          err
);
    AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> rvalid);                                              // R2
    AST_BEATS_PAIRED: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |=> rvalid);                                      // R2
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata_rise == '0 && rdata_fall == '0));            // R2
    AST_GAP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && busy) |=> err);                            // R7
    AST_ONE_GO: assert property (@(posedge clk) disable iff (rst)
        (rd_go || wr_go) |=> !(rd_go || wr_go));                        // R7
    AST_DUAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> err);                                      // R8
    AST_NOT_BOTH_GO: assert property (@(posedge clk) disable iff (rst)
        !(rd_go && wr_go));                                             // R8
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                   // R9
endmodule

bind b4_cio_sram b4_sram_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst(rst),
    .rd_en(rd_en_i), .wr_en(wr_en_i),
    .busy(busy_w), .rd_go(rd_go_w), .wr_go(wr_go_w),
    .rvalid(rvalid_o),
    .rdata_rise(rdata_rise_o), .rdata_fall(rdata_fall_o),
    .err(proto_err_o)
);

// File: tb/b4_cio_sram_tb.sv
`timescale 1ns/1ps
module b4_cio_sram_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wdr = '0, wdf = '0;
    logic [1:0]  ber = '0, bef = '0;
    logic [15:0] rdr, rdf;
    logic        rvalid, perr;

    int ntests = 0;
    int nfail  = 0;
    logic [15:0] mdl [0:31];

    always #2 clk = ~clk;

    b4_cio_sram dut_i (
        .clk(clk), .rst(rst), .addr_i(addr),
        .rd_en_i(rd_en), .wr_en_i(wr_en),
        .wdata_rise_i(wdr), .wdata_fall_i(wdf),
        .wbe_rise_i(ber), .wbe_fall_i(bef),
        .rdata_rise_o(rdr), .rdata_fall_o(rdf),
        .rvalid_o(rvalid), .proto_err_o(perr)
    );

    // {addr, seed, per-beat lane enables: bits [2i+1:2i] for beat i}
    localparam logic [28:0] VEC [8] = '{
        {5'd0,  16'hA5C3, 8'hFF},
        {5'd7,  16'h1234, 8'hFF},
        {5'd5,  16'hBEEF, 8'b01_10_01_10},
        {5'd12, 16'h0F0F, 8'hFF},
        {5'd14, 16'hFFFF, 8'h00},
        {5'd31, 16'h7E81, 8'b11_00_11_00},
        {5'd16, 16'h5555, 8'hFF},
        {5'd19, 16'hC001, 8'b00_11_00_01}
    };

    function automatic logic [15:0] bw(input logic [15:0] s, input int i);
        return s ^ (16'h0101 * 16'(i + 1));
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mdl_write(input logic [4:0] a, input logic [15:0] s, input logic [7:0] be);
        for (int i = 0; i < 4; i++)
            for (int b = 0; b < 2; b++)
                if (be[2*i+b]) mdl[{a[4:2], 2'(i)}][8*b +: 8] = bw(s, i)[8*b +: 8];
    endtask

    task automatic chk_beats(input logic [2:0] row, input logic hi, input string req);
        chk({15'd0, rvalid}, 16'd1, req);
        chk(rdr, mdl[{row, hi, 1'b0}], req);
        chk(rdf, mdl[{row, hi, 1'b1}], req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 0; wr_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int w = 0; w < 32; w++) mdl[w] = '0;
    endtask

    task automatic drive_beats(input logic [15:0] s, input logic [7:0] be, input logic hi);
        wdr = bw(s, hi ? 2 : 0);  wdf = bw(s, hi ? 3 : 1);
        ber = hi ? be[5:4] : be[1:0];
        bef = hi ? be[7:6] : be[3:2];
    endtask

    task automatic clear_data();
        wdr = '0; wdf = '0; ber = '0; bef = '0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] s, input logic [7:0] be);
        @(negedge clk); addr = a; wr_en = 1;
        @(negedge clk); wr_en = 0; drive_beats(s, be, 1'b0);
        @(negedge clk); drive_beats(s, be, 1'b1);
        @(negedge clk); clear_data();
        mdl_write(a, s, be);
    endtask

    task automatic do_read(input logic [4:0] a, input string req);
        @(negedge clk); addr = a; rd_en = 1;
        @(negedge clk); rd_en = 0;
        @(negedge clk); chk_beats(a[4:2], 1'b0, req);
        @(negedge clk); chk_beats(a[4:2], 1'b1, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state and cleared storage
        @(negedge clk);
        chk({15'd0, rvalid}, 16'd0, "R1 rvalid");
        chk(rdr, 16'd0, "R1 rdata_rise");
        chk(rdf, 16'd0, "R1 rdata_fall");
        chk({15'd0, perr}, 16'd0, "R1 err");
        do_read(5'd9, "R1 cleared word");

        // table: R4 beat capture, R5 lane masks, R3 unaligned addresses
        for (int k = 0; k < 8; k++)
            do_write(VEC[k][28:24], VEC[k][23:8], VEC[k][7:0]);
        for (int k = 0; k < 8; k++)
            do_read(VEC[k][28:24], "R4/R5 table readback");
        do_read(5'd4, "R3 aligned alias");
        do_read(5'd6, "R3 unaligned alias");
        // R2 bus quiet after the burst
        @(negedge clk);
        chk({15'd0, rvalid}, 16'd0, "R2 rvalid low after burst");
        chk(rdr, 16'd0, "R2 rise zero when idle");
        chk(rdf, 16'd0, "R2 fall zero when idle");

        // R6 coherency: partial write, then read two cycles later
        do_write(5'd8, 16'h2468, 8'hFF);
        @(negedge clk); addr = 5'd9; wr_en = 1;
        @(negedge clk); wr_en = 0; drive_beats(16'h9ACE, 8'b10_11_11_01, 1'b0);
        @(negedge clk); drive_beats(16'h9ACE, 8'b10_11_11_01, 1'b1);
        addr = 5'd8; rd_en = 1;
        mdl_write(5'd9, 16'h9ACE, 8'b10_11_11_01);
        @(negedge clk); rd_en = 0; clear_data();
        @(negedge clk); chk_beats(3'd2, 1'b0, "R6 forwarded beats 0/1");
        @(negedge clk); chk_beats(3'd2, 1'b1, "R6 beats 2/3");

        // R10 commands two cycles apart
        @(negedge clk); addr = 5'd20; wr_en = 1;
        @(negedge clk); wr_en = 0; drive_beats(16'h1357, 8'hFF, 1'b0);
        @(negedge clk); addr = 5'd24; wr_en = 1; drive_beats(16'h1357, 8'hFF, 1'b1);
        @(negedge clk); wr_en = 0; drive_beats(16'hFACE, 8'hFF, 1'b0);
        @(negedge clk); addr = 5'd20; rd_en = 1; drive_beats(16'hFACE, 8'hFF, 1'b1);
        mdl_write(5'd20, 16'h1357, 8'hFF);
        mdl_write(5'd24, 16'hFACE, 8'hFF);
        @(negedge clk); rd_en = 0; clear_data();
        @(negedge clk); addr = 5'd24; rd_en = 1; chk_beats(3'd5, 1'b0, "R10 first read");
        @(negedge clk); rd_en = 0; chk_beats(3'd5, 1'b1, "R10 first read");
        @(negedge clk); chk_beats(3'd6, 1'b0, "R10 second read");
        @(negedge clk); chk_beats(3'd6, 1'b1, "R10 second read");
        chk({15'd0, perr}, 16'd0, "R10 no error");

        // R7 command one cycle after an accepted one is dropped
        do_reset();
        @(negedge clk); addr = 5'd0; rd_en = 1;
        @(negedge clk); rd_en = 0; addr = 5'd4; wr_en = 1;
        @(negedge clk); wr_en = 0; drive_beats(16'hDEAD, 8'hFF, 1'b0);
        chk_beats(3'd0, 1'b0, "R7 first read intact");
        @(negedge clk); drive_beats(16'hDEAD, 8'hFF, 1'b1);
        chk_beats(3'd0, 1'b1, "R7 first read intact");
        @(negedge clk); clear_data();
        chk({15'd0, perr}, 16'd1, "R7 error raised");
        do_read(5'd4, "R7 ignored write left word unchanged");

        // R8 read and write together
        do_reset();
        chk({15'd0, perr}, 16'd0, "R9 cleared by reset");
        do_write(5'd20, 16'h4321, 8'hFF);
        @(negedge clk); addr = 5'd20; rd_en = 1; wr_en = 1;
        @(negedge clk); rd_en = 0; wr_en = 0; drive_beats(16'hBAD0, 8'hFF, 1'b0);
        @(negedge clk); drive_beats(16'hBAD0, 8'hFF, 1'b1);
        chk_beats(3'd5, 1'b0, "R8 read performed");
        @(negedge clk); clear_data();
        chk_beats(3'd5, 1'b1, "R8 read performed");
        chk({15'd0, perr}, 16'd1, "R8 error raised");
        do_read(5'd20, "R8 write dropped");
        repeat (5) @(negedge clk);
        chk({15'd0, perr}, 16'd1, "R9 error sticky");

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule